// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a burst-capable synchronous memory. A load command captures a base address. Each advance command then moves the two lowest address bits to the next beat of a four-beat burst, while the upper bits stay where the load put them. A static strap input picks the beat order. With the strap high, the order is interleaved: the start offset XOR a running count. With the strap low, the order is linear: the start offset plus the count, wrapping modulo four. The board should pull the strap high so that a floating pin gives interleaved order. The strap must not change while a burst is running.

All commands are qualified by an active-low clock enable. While the enable is high, nothing changes. A deselect input returns the block to its idle state, and the address output holds. Advance commands are ignored in the idle state, so after reset or after a deselect a load must come first.

Control is a two-state machine. The states are `ST_IDLE` (no valid burst) and `ST_BURST` (a base address is held). It has four transitions:
- IDLE→BURST, the *load* transition.
- BURST→IDLE, the *deselect* transition.
- BURST→BURST, by *advance* or *reload*.
- IDLE→IDLE, for any other command, which is a *stay*.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `addr_out` is 0 and the block is in the idle state.
- R2: A load (`clk_en_n`=0, `adv_ld`=0, `desel`=0) at a clock edge makes `addr_out` equal `base_addr` after that edge, with the beat count reset to 0.
- R3: With `mode_intlv`=0, after k advances since the load, `addr_out[1:0]` = (start + k) mod 4, wrapping from 3 to 0.
- R4: With `mode_intlv`=1, after k advances since the load, `addr_out[1:0]` = start XOR (k mod 4).
- R5: `addr_out[ADDR_W-1:2]` does not change on advances; only a load changes it.
- R6: While `clk_en_n`=1, `addr_out` and the burst position hold, whatever the other inputs do. A later advance continues the same sequence.
- R7: `desel`=1 at an enabled edge moves the block to idle. `addr_out` holds, and later advances leave it unchanged until a load.
- R8: Advances after reset and before any load leave `addr_out` at 0.
- R9: When `desel`=1 coincides with a load command at an enabled edge, the deselect wins: no address is captured.
- R10: `desel`=1 while `clk_en_n`=1 has no effect. A following advance still steps the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new base |
| desel | input | 1 | 1 = deselect (go idle), has priority over load and advance |
| base_addr | input | ADDR_W | Base address captured on a load |
| mode_intlv | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Current burst address |

## Verification
Deselect and load can fall in the same cycle, because a load is signalled by `adv_ld` low and `desel` is a separate pin. The bench drives both active at one enabled edge after a burst has progressed. It then expects the old address to stay on `addr_out` and a following advance to be ignored. Stall against deselect is provoked the same way, with `clk_en_n` high. For this case the bench judges the outcome by the burst stepping on the next enabled advance. Expected addresses come from an arithmetic model of the offset and count.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_t;
endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en_n,
    input  logic         adv_ld,
    input  logic         desel,
    output burst_state_t state,
    output logic         do_load,
    output logic         do_step
);
    burst_state_t nxt;
    logic         fire;

    always_comb begin
        fire    = !clk_en_n;
        do_load = fire && !desel && !adv_ld;
        do_step = fire && !desel && adv_ld && (state == ST_BURST);
        nxt     = state;
        unique case (state)
            ST_IDLE:  if (do_load) nxt = ST_BURST;           // load
            ST_BURST: if (fire && desel) nxt = ST_IDLE;      // deselect
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    p_idle_after_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && desel) |=> (state == ST_IDLE));

    p_stall_holds_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(state));
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_load,
    input  logic          do_step,
    input  logic          mode_intlv,
    input  logic [BW-1:0] start_in,
    output logic [BW-1:0] off
);
    logic [BW-1:0] start_q, cnt_q, lin, ilv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (do_load) begin
            start_q <= start_in;
            cnt_q   <= '0;
        end else if (do_step) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign lin = start_q + cnt_q;

    for (genvar i = 0; i < BW; i++) begin : g_ilv
        assign ilv[i] = start_q[i] ^ cnt_q[i];
    end

    assign off = mode_intlv ? ilv : lin;

    p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && !mode_intlv) |=> (!mode_intlv -> (off == $past(off) + 1'b1)));

    p_load_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (off == $past(start_in)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic              desel,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              mode_intlv,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int BW = 2;
    localparam int UW = ADDR_W - BW;

    burst_state_t  state;
    logic          do_load, do_step;
    logic [UW-1:0] upper_q;
    logic [BW-1:0] off;

    burst_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .desel(desel), .state(state), .do_load(do_load), .do_step(do_step)
    );

    burst_seq #(.BW(BW)) u_seq (
        .clk(clk), .rst_n(rst_n), .do_load(do_load), .do_step(do_step),
        .mode_intlv(mode_intlv), .start_in(base_addr[BW-1:0]), .off(off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       upper_q <= '0;
        else if (do_load) upper_q <= base_addr[ADDR_W-1:BW];
    end

    assign addr_out = {upper_q, off};

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !desel && !adv_ld) |=> (addr_out == $past(base_addr)));

    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ld |=> (addr_out[ADDR_W-1:BW] == $past(addr_out[ADDR_W-1:BW])));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && $stable(mode_intlv)) |=> $stable(addr_out));

    p_idle_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && adv_ld && $stable(mode_intlv)) |=> $stable(addr_out));

    p_desel_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && desel && $stable(mode_intlv)) |=> $stable(addr_out));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          adv_ld = 1'b1;
    logic          desel = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          mode_intlv = 1'b1;
    logic [AW-1:0] addr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_start = '0;
    int            m_k = 0;
    bit            m_valid = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .desel(desel), .base_addr(base_addr), .mode_intlv(mode_intlv),
        .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] expect_addr();
        logic [1:0] k2;
        k2 = 2'(m_k);
        return {m_up, mode_intlv ? (m_start ^ k2) : 2'(m_start + k2)};
    endfunction

    task automatic check(string req);
        logic [AW-1:0] e;
        e = expect_addr();
        n_cmp++;
        if (addr_out !== e) begin
            n_bad++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, e);
        end
    endtask

    // Drive one command at a negative edge, let the rising edge take it, check at the next negative edge.
    task automatic cyc(bit en_n, bit adl, bit ds, logic [AW-1:0] base, string req);
        clk_en_n  = en_n;
        adv_ld    = adl;
        desel     = ds;
        base_addr = base;
        @(posedge clk);
        if (!en_n) begin
            if (ds) m_valid = 1'b0;
            else if (!adl) begin
                m_up = base[AW-1:2]; m_start = base[1:0]; m_k = 0; m_valid = 1'b1;
            end else if (m_valid) m_k++;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R8: advances before any load are ignored
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 8'hA5, "R8");

        // R2, R3, R4, R5: full sweep of mode, start offset and several upper values
        for (int m = 0; m < 2; m++) begin
            mode_intlv = m[0];
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    logic [AW-1:0] b;
                    b = {6'(u * 21 + 5), 2'(s)};
                    cyc(0, 0, 0, b, "R2");
                    for (int a = 0; a < 6; a++)
                        cyc(0, 1, 0, 8'hFF, m ? "R4 R5" : "R3 R5");
                end
            end
        end

        // R6: stall holds position, then the sequence resumes
        mode_intlv = 1'b0;
        cyc(0, 0, 0, 8'h3E, "R2");
        cyc(0, 1, 0, 8'h00, "R3");
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 8'h00, "R6");
        cyc(1, 0, 0, 8'h55, "R6");
        cyc(0, 1, 0, 8'h00, "R6");

        // R7: deselect goes idle, advances ignored, load recovers
        mode_intlv = 1'b1;
        cyc(0, 0, 0, 8'h92, "R2");
        cyc(0, 1, 0, 8'h00, "R4");
        cyc(0, 1, 1, 8'h00, "R7");
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 8'h00, "R7");
        cyc(0, 0, 0, 8'h71, "R7");
        cyc(0, 1, 0, 8'h00, "R7");

        // R9: deselect and load in the same cycle, deselect wins
        cyc(0, 1, 0, 8'h00, "R4");
        cyc(0, 0, 1, 8'hC3, "R9");
        cyc(0, 1, 0, 8'h00, "R9");

        // R10: deselect under stall has no effect
        cyc(0, 0, 0, 8'h4C, "R2");
        cyc(1, 1, 1, 8'h00, "R10");
        cyc(0, 1, 0, 8'h00, "R10");
        cyc(0, 1, 0, 8'h00, "R10");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule